// File: doc/BRIEF.md
# NAND Bus Cycle Strobe Timer

This block generates the control strobes for one elementary NAND bus cycle: a command latch, an address latch, a data byte write or a data byte read. A requester presents the kind of cycle, a byte and a chip-select index while the block is idle. Two packed 32-bit timing words, loaded by software with tick counts already rounded up from the device's nanosecond limits, set the length of every phase. The block then walks through a set-up phase with the chip enable low, a strobe phase with WE# or RE# low, a hold phase and an extend phase. After that it pulses `done` and returns to idle.

Write-type cycles (command, address and data write) drive the byte on the data pins for the whole time the strobe window is open. Read cycles capture the data pins while RE# is still low, at the moment the access time has elapsed. A separate registered status word reports the ready/busy line of the selected chip in its top bit.

Top module: `nand_strobe_timer`

## Requirements
- R1: After reset every chip enable and both WE# and RE# are high, CLE, ALE, `dq_oe` and `done` are low, `idle` is high, and `status_word` and `rd_data` are zero.
- R2: A tick field holding zero acts as one clock tick, so each phase lasts at least one cycle.
- R3: Every cycle starts with a set-up phase of eff(timing_wr[31:24]) cycles. In this phase the selected chip enable is low and both strobes are high. Here eff(f) means f, or 1 when f is 0.
- R4: For request kinds 00, 01 and 10, WE# is low for eff(timing_wr[15:8]) − eff(timing_wr[7:0]) cycles, or 1 cycle when that difference is not positive. The hold phase then lasts eff(timing_wr[7:0]) cycles and the extend phase eff(timing_wr[23:16]) cycles. RE# stays high.
- R5: For request kind 11, RE# is low for the larger of eff(timing_rd[31:24]) and eff(timing_rd[15:8]) cycles. The hold phase then lasts eff(timing_rd[23:16]) cycles and the extend phase eff(timing_rd[7:0]) cycles. WE# stays high.
- R6: A read captures `dq_in` at the clock edge that ends the eff(timing_rd[31:24])-th cycle with RE# low. `rd_data` holds that value until the next read. Write-type cycles leave `rd_data` unchanged.
- R7: Kind 00 raises CLE and kind 01 raises ALE through the set-up, strobe and hold phases, and both are low in the extend phase. For kinds 00, 01 and 10, `dq_oe` is high in those same three phases with `dq_out` equal to the request byte. For kind 11, `dq_oe` stays low.
- R8: Only the chip enable chosen by `req_cs` at acceptance goes low, and it stays low for every cycle of set-up, strobe, hold and extend.
- R9: `done` is high for exactly one cycle: the cycle right after the last extend cycle. In that cycle all chip enables are high and `idle` is high.
- R10: A request is accepted only on a clock edge where `idle` is high. A request held while the block is busy has no effect on the strobes, the byte or the cycle length.
- R11: `status_word[31]` equals `rdy_in[req_cs]` as sampled at the previous clock edge, and `status_word[30:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `idle` is high |
| req_kind | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_byte | input | 8 | Byte for command, address or write |
| req_cs | input | 2 | Chip-select index for the cycle and for the status word |
| timing_wr | input | 32 | Ready delay, write extend, write cycle, write high (bit 31 down) |
| timing_rd | input | 32 | Read access, read hold, read low, read extend (bit 31 down) |
| dq_in | input | 8 | Data pins from the device |
| rdy_in | input | 4 | Ready/busy lines per chip, 1 means ready |
| idle | output | 1 | Block can take a request |
| done | output | 1 | One-cycle pulse after the extend phase ends |
| ce_n | output | 4 | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| dq_out | output | 8 | Data pins toward the device |
| dq_oe | output | 1 | Output enable for `dq_out` |
| rd_data | output | 8 | Last byte captured by a read |
| status_word | output | 32 | Bit 31 is the selected chip's ready flag |

## Verification
The strobes first change in the cycle after the accepting edge. `done` is due in the cycle after set-up + strobe + hold + extend cycles. `status_word` follows `rdy_in` one edge later, and `rd_data` changes at the edge that ends the access count. The bench drives inputs and samples outputs on falling edges. It counts, cycle by cycle, how long each strobe and enable stays in each state, and compares those counts against phase lengths computed from the timing fields. A sweep over every field value from 0 to 3 for each request kind covers the zero-field, clamped-difference and access-longer-than-pulse cases.

// File: rtl/nand_tm_pkg.sv
package nand_tm_pkg;
  localparam int TM_FW = 8;

  typedef enum logic [1:0] {K_CMD = 2'b00, K_ADDR = 2'b01, K_WRITE = 2'b10, K_READ = 2'b11} req_kind_e;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_EXT} phase_e;

  typedef struct packed {
    logic [TM_FW-1:0] setup;
    logic [TM_FW-1:0] strobe;
    logic [TM_FW-1:0] hold;
    logic [TM_FW-1:0] ext;
    logic [TM_FW-1:0] acc;
  } phase_len_t;

  // zero field counts as a single tick
  function automatic logic [TM_FW-1:0] tick_eff(input logic [TM_FW-1:0] f);
    return (f == '0) ? TM_FW'(1) : f;
  endfunction

  // strobe-low length from a cycle length and a high time, clamped to one
  function automatic logic [TM_FW-1:0] low_ticks(input logic [TM_FW-1:0] cyc,
                                                 input logic [TM_FW-1:0] hi);
    logic [TM_FW-1:0] ec, eh;
    ec = tick_eff(cyc);
    eh = tick_eff(hi);
    return (ec > eh) ? ec - eh : TM_FW'(1);
  endfunction

  function automatic logic [TM_FW-1:0] span_max(input logic [TM_FW-1:0] a,
                                                input logic [TM_FW-1:0] b);
    return (tick_eff(a) > tick_eff(b)) ? tick_eff(a) : tick_eff(b);
  endfunction

  function automatic phase_len_t plan_lengths(input req_kind_e kind,
                                              input logic [4*TM_FW-1:0] tw,
                                              input logic [4*TM_FW-1:0] tr);
    phase_len_t l;
    l.setup = tick_eff(tw[4*TM_FW-1:3*TM_FW]);
    if (kind == K_READ) begin
      l.strobe = span_max(tr[4*TM_FW-1:3*TM_FW], tr[2*TM_FW-1:TM_FW]);
      l.hold   = tick_eff(tr[3*TM_FW-1:2*TM_FW]);
      l.ext    = tick_eff(tr[TM_FW-1:0]);
      l.acc    = tick_eff(tr[4*TM_FW-1:3*TM_FW]);
    end else begin
      l.strobe = low_ticks(tw[2*TM_FW-1:TM_FW], tw[TM_FW-1:0]);
      l.hold   = tick_eff(tw[TM_FW-1:0]);
      l.ext    = tick_eff(tw[3*TM_FW-1:2*TM_FW]);
      l.acc    = TM_FW'(1);
    end
    return l;
  endfunction
endpackage

// File: rtl/nand_tm_phase_seq.sv
module nand_tm_phase_seq
  import nand_tm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  phase_len_t       lens,
  output phase_e           phase,
  output logic [TM_FW-1:0] tick,
  output logic             fin
);
  logic [TM_FW-1:0] cur_len;
  logic             last;

  always_comb begin
    case (phase)
      PH_SETUP:  cur_len = lens.setup;
      PH_STROBE: cur_len = lens.strobe;
      PH_HOLD:   cur_len = lens.hold;
      PH_EXT:    cur_len = lens.ext;
      default:   cur_len = TM_FW'(1);
    endcase
  end

  assign last = (tick == cur_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tick  <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase <= PH_SETUP;
          tick  <= TM_FW'(1);
        end
      end else if (last) begin
        tick <= TM_FW'(1);
        case (phase)
          PH_SETUP:  phase <= PH_STROBE;
          PH_STROBE: phase <= PH_HOLD;
          PH_HOLD:   phase <= PH_EXT;
          default: begin
            phase <= PH_IDLE;
            tick  <= '0;
            fin   <= 1'b1;
          end
        endcase
      end else begin
        tick <= tick + TM_FW'(1);
      end
    end
  end
endmodule

// File: rtl/nand_tm_strobe_dec.sv
module nand_tm_strobe_dec
  import nand_tm_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  phase_e            phase,
  input  req_kind_e         kind,
  input  logic [CS_W-1:0]   cs,
  output logic [NUM_CS-1:0] ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              dq_oe
);
  logic active, window, strobing;

  assign active   = (phase != PH_IDLE);
  assign window   = active && (phase != PH_EXT);
  assign strobing = (phase == PH_STROBE);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign ce_n[g] = !(active && (cs == CS_W'(g)));
  end

  assign cle   = window && (kind == K_CMD);
  assign ale   = window && (kind == K_ADDR);
  assign we_n  = !(strobing && (kind != K_READ));
  assign re_n  = !(strobing && (kind == K_READ));
  assign dq_oe = window && (kind != K_READ);
endmodule

// File: rtl/nand_tm_ready_mon.sv
module nand_tm_ready_mon #(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] rdy_in,
  input  logic [CS_W-1:0]   sel,
  output logic [31:0]       status_word
);
  logic rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_in[sel];
  end

  assign status_word = {rdy_q, 31'd0};
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nand_tm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int TW_W = 4 * TM_FW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_byte,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [TW_W-1:0]   timing_wr,
  input  logic [TW_W-1:0]   timing_rd,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [NUM_CS-1:0] rdy_in,
  output logic              idle,
  output logic              done,
  output logic [NUM_CS-1:0] ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic [31:0]       status_word
);
  phase_e           phase;
  logic [TM_FW-1:0] tick;
  logic             accept;
  logic             samp_fire;
  req_kind_e        kind_q;
  logic [DATA_W-1:0] byte_q;
  logic [CS_W-1:0]  cs_q;
  phase_len_t       lens_q;

  assign idle   = (phase == PH_IDLE);
  assign accept = req_valid && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_CMD;
      byte_q <= '0;
      cs_q   <= '0;
      lens_q <= '0;
    end else if (accept) begin
      kind_q <= req_kind_e'(req_kind);
      byte_q <= req_byte;
      cs_q   <= req_cs;
      lens_q <= plan_lengths(req_kind_e'(req_kind), timing_wr, timing_rd);
    end
  end

  nand_tm_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .lens  (lens_q),
    .phase (phase),
    .tick  (tick),
    .fin   (done)
  );

  nand_tm_strobe_dec #(.NUM_CS(NUM_CS)) u_dec (
    .phase (phase),
    .kind  (kind_q),
    .cs    (cs_q),
    .ce_n  (ce_n),
    .cle   (cle),
    .ale   (ale),
    .we_n  (we_n),
    .re_n  (re_n),
    .dq_oe (dq_oe)
  );

  // capture point: access count reached while the read strobe is low
  assign samp_fire = (phase == PH_STROBE) && (kind_q == K_READ) && (tick == lens_q.acc);

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_data <= '0;
    else if (samp_fire) rd_data <= dq_in;
  end

  assign dq_out = byte_q;

  nand_tm_ready_mon #(.NUM_CS(NUM_CS)) u_rdy (
    .clk         (clk),
    .rst_n       (rst_n),
    .rdy_in      (rdy_in),
    .sel         (req_cs),
    .status_word (status_word)
  );
endmodule

// File: rtl/nand_tm_chk.sv
module nand_tm_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] ce_n,
  input logic              cle,
  input logic              ale,
  input logic              we_n,
  input logic              re_n,
  input logic              dq_oe,
  input logic              done,
  input logic              idle,
  input logic              samp,
  input logic [31:0]       status_word
);
  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R4
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (ce_n == '1) && we_n && re_n && !cle && !ale && !dq_oe); // R1
  AST_DONE_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle && $past(ce_n != '1)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_SAMPLE_RE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> !re_n); // R6
  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> re_n); // R7
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[30:0] == 31'd0); // R11
endmodule

bind nand_strobe_timer nand_tm_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_n        (ce_n),
  .cle         (cle),
  .ale         (ale),
  .we_n        (we_n),
  .re_n        (re_n),
  .dq_oe       (dq_oe),
  .done        (done),
  .idle        (idle),
  .samp        (samp_fire),
  .status_word (status_word)
);

// File: tb/nand_strobe_timer_tb.sv
module nand_strobe_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [7:0]  req_byte = 8'h00;
  logic [1:0]  req_cs = 2'b00;
  logic [31:0] timing_wr = 32'h0;
  logic [31:0] timing_rd = 32'h0;
  logic [7:0]  dq_in = 8'hEE;
  logic [3:0]  rdy_in = 4'h0;
  logic        idle, done, cle, ale, we_n, re_n, dq_oe;
  logic [3:0]  ce_n;
  logic [7:0]  dq_out, rd_data;
  logic [31:0] status_word;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  nand_strobe_timer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_byte(req_byte), .req_cs(req_cs), .timing_wr(timing_wr), .timing_rd(timing_rd),
    .dq_in(dq_in), .rdy_in(rdy_in), .idle(idle), .done(done), .ce_n(ce_n),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_data(rd_data), .status_word(status_word)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ef(input int f);
    return f + ((f == 0) ? 1 : 0);
  endfunction

  task automatic run_txn(input int kind, input int bval, input int cs,
                         input logic [31:0] tw, input logic [31:0] tr, input bit poke);
    int s, p, h, x, acc, n, tot, pre, lw, lr, nc, na, noe, badq, badce, k;
    bit seen;
    logic [7:0] base, rd_before;
    s = ef(tw[31:24]);
    if (kind == 3) begin
      acc = ef(tr[31:24]);
      p = (ef(tr[15:8]) > acc) ? ef(tr[15:8]) : acc;
      h = ef(tr[23:16]);
      x = ef(tr[7:0]);
    end else begin
      acc = 0;
      p = ef(tw[15:8]) - ef(tw[7:0]);
      if (p < 1) p = 1;
      h = ef(tw[7:0]);
      x = ef(tw[23:16]);
    end
    base = 8'(bval * 3 + 8'h10);
    rd_before = rd_data;
    tot = 0; pre = 0; lw = 0; lr = 0; nc = 0; na = 0; noe = 0; badq = 0; badce = 0; k = 0;
    seen = 0; n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_byte = 8'(bval); req_cs = 2'(cs);
    timing_wr = tw; timing_rd = tr;
    @(negedge clk);
    if (poke) begin
      // R10: a command request with another byte held while busy
      req_kind = 2'b00; req_byte = ~8'(bval); req_cs = 2'(cs + 1);
      timing_wr = 32'h0; timing_rd = 32'h0;
    end else begin
      req_valid = 1'b0;
    end
    while (!done && n < 2000) begin
      if (ce_n[cs] == 1'b0) tot++;
      if ((ce_n | (4'b1 << cs)) != 4'hF) badce++;
      if (!we_n || !re_n) seen = 1;
      if (!seen && ce_n[cs] == 1'b0) pre++;
      if (!we_n) lw++;
      if (!re_n) begin
        lr++; k++; dq_in = 8'(base + k);
      end
      if (cle) nc++;
      if (ale) na++;
      if (dq_oe) begin
        noe++;
        if (dq_out != 8'(bval)) badq++;
      end
      n++;
      if (poke && n == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(done == 1'b1 && idle == 1'b1 && ce_n == 4'hF, "R9 done/idle at end", int'(done), 1);
    chk(tot == s + p + h + x, "R9 cycles before done", tot, s + p + h + x);
    chk(pre == s, (tw[31:24] == 0) ? "R2 R3 setup length" : "R3 setup length", pre, s);
    if (kind == 3) begin
      chk(lr == p && lw == 0, "R5 RE low length", lr, p);
      chk(rd_data == 8'(base + acc), "R6 captured byte", rd_data, 8'(base + acc));
    end else begin
      chk(lw == p && lr == 0, "R4 WE low length", lw, p);
      chk(rd_data == rd_before, "R6 rd_data kept on write", rd_data, rd_before);
    end
    chk(nc == ((kind == 0) ? s + p + h : 0), "R7 CLE cycles", nc, (kind == 0) ? s + p + h : 0);
    chk(na == ((kind == 1) ? s + p + h : 0), "R7 ALE cycles", na, (kind == 1) ? s + p + h : 0);
    chk(noe == ((kind != 3) ? s + p + h : 0), "R7 dq_oe cycles", noe, (kind != 3) ? s + p + h : 0);
    chk(badq == 0, "R7 dq_out byte", badq, 0);
    chk(badce == 0, "R8 other chip enables", badce, 0);
    dq_in = 8'hEE;
    @(negedge clk);
    chk(done == 1'b0 && idle == 1'b1, "R9 R10 done pulse ends, no extra accept", int'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !finished) begin
        finished = 1;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce_n == 4'hF && we_n && re_n && !cle && !ale, "R1 strobes at reset", int'(ce_n), 15);
    chk(!dq_oe && !done && idle, "R1 control at reset", int'({dq_oe, done, idle}), 1);
    chk(status_word == 32'h0 && rd_data == 8'h0, "R1 status/data at reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 readiness per chip select
    for (int pat = 0; pat < 16; pat++) begin
      for (int c = 0; c < 4; c++) begin
        rdy_in = 4'(pat); req_cs = 2'(c);
        @(negedge clk);
        chk(status_word == {rdy_in[c], 31'd0}, "R11 status word", int'(status_word[31]), int'(rdy_in[c]));
      end
    end
    rdy_in = 4'h0;

    // sweep of all small field values per kind
    for (int kind = 0; kind < 4; kind++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] w;
        w = {6'd0, 2'(v >> 6), 6'd0, 2'(v >> 4), 6'd0, 2'(v >> 2), 6'd0, 2'(v)};
        if (kind == 3) run_txn(kind, v, v % 4, 32'h01020304 & {8'h03, 24'h0} | {8'(v & 3), 24'h0}, w, 0);
        else           run_txn(kind, v, v % 4, w, 32'h02010203, 0);
      end
    end

    // long fields, including a large clamped difference and long access
    run_txn(2, 8'hA5, 1, 32'h05_0C_28_07, 32'h0, 0);
    run_txn(3, 8'h3C, 2, 32'h02_00_00_00, 32'h1E_03_0A_04, 0);
    run_txn(0, 8'h70, 3, 32'h03_02_04_09, 32'h0, 0);
    // R10: requests held during a busy cycle are ignored
    run_txn(2, 8'h5A, 0, 32'h04_03_09_02, 32'h0, 1);
    run_txn(3, 8'h11, 3, 32'h03_00_00_00, 32'h04_02_06_02, 1);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule